// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches a group of input pins and raises a sticky interrupt flag when the pins no longer match a reference copy. The reference copy is the port value that software last read. The raw pins first pass through a synchroniser. After that, the synchronised value is compared with the reference register, but only in the comparison slots marked by a phase strobe (one per instruction cycle). A per-pin enable mask chooses which pins take part in the comparison.

A difference on an enabled pin sets a latched mismatch indication, and that indication drives the interrupt flag. The mismatch does not clear when the pins go back to their earlier values. Only a port read clears it. A port read captures the synchronised pins into the read-data register and into the reference register in the same cycle. A software clear of the flag has no effect while the mismatch is still latched, so the flag stays high.

The port read is a single-cycle strobe with no back-pressure. The value it captures is presented on the read-data output from the following cycle. It then holds until the next read.

Top module: `pin_change_detect`

## Requirements
- R1: During and right after reset, `flag_o` is 0 and `rd_data_o` is all zeros. The reference register and both synchroniser stages also reset to zero.
- R2: A raw pin value passes through two synchroniser flops. A pin change driven before clock edge k can first be compared at edge k+2. `flag_o` then rises at edge k+3.
- R3: A comparison happens only at a clock edge where `q1_i` is 1. While `q1_i` is 0, a pin difference never sets the mismatch.
- R4: At a comparison edge, a difference between the synchronised pins and the reference on any enabled pin sets the mismatch. `flag_o` is 1 from the next edge on.
- R5: A pin whose `enable_i` bit is 0 is ignored by the comparison. Its bit of the reference register still loads on a port read, so enabling it later after a read raises no flag for a change made before that read.
- R6: The mismatch is sticky. It stays set when the pins return to their earlier value or change again.
- R7: A `flag_clr_i` pulse while the mismatch is latched leaves `flag_o` at 1.
- R8: A port read (`rd_i` = 1 at an edge) clears the mismatch at that edge. A `flag_clr_i` at any later edge then clears `flag_o`, provided no new mismatch has been latched.
- R9: If `rd_i` and `q1_i` are both 1 at the same edge, the read wins and no mismatch is set. A pin value that reached the synchroniser output at that edge is caught at the next comparison.
- R10: On a read, `rd_data_o` takes the synchronised pin value from the edge of the read. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | WIDTH | Raw asynchronous pin inputs |
| enable_i | input | WIDTH | Per-pin comparison enable |
| rd_i | input | 1 | Port read strobe; reloads the reference register |
| rd_data_o | output | WIDTH | Value captured by the most recent port read |
| q1_i | input | 1 | Comparison slot strobe |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| flag_o | output | 1 | Sticky change interrupt flag |

## Verification
Every enable mask of a four-pin configuration is swept under a pseudo-random pin sequence. The comparison strobe is run at spacings of one, two and four cycles, which tells apart comparisons made every cycle from comparisons made only in marked slots. Port reads and clear pulses are mixed into the sweep. This separates the sticky latched behaviour from a plain level comparison, and shows a blocked clear apart from a successful one. Directed sequences cover the remaining cases:
- the exact synchroniser latency;
- pins that return to their earlier value;
- a read that falls in the same cycle as a comparison slot, with a pin edge in flight;
- a masked pin whose reference bit is reloaded before the pin is enabled.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // Synchroniser depth used for the raw pins
  localparam int unsigned SYNC_DEPTH = 2;

  // Returns 1 when any enabled bit of cur differs from ref
  function automatic logic masked_diff(input logic [63:0] cur,
                                       input logic [63:0] refv,
                                       input logic [63:0] en);
    return |((cur ^ refv) & en);
  endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcd_ref_latch.sv
module pcd_ref_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] pin_s,
  output logic [WIDTH-1:0] ref_q,
  output logic [WIDTH-1:0] rd_q
);
  // Port input latch and comparison reference load together on a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      rd_q  <= '0;
    end else if (load) begin
      ref_q <= pin_s;
      rd_q  <= pin_s;
    end
  end
endmodule

// File: rtl/pcd_compare.sv
module pcd_compare #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot,
  input  logic             rd,
  input  logic [WIDTH-1:0] pin_s,
  input  logic [WIDTH-1:0] ref_q,
  input  logic [WIDTH-1:0] en,
  output logic             mis_q
);
  import pcd_pkg::*;

  logic hit;

  always_comb begin
    hit = masked_diff(64'(pin_s), 64'(ref_q), 64'(en));
  end

  // Read has priority over a comparison slot in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mis_q <= 1'b0;
    else if (rd)         mis_q <= 1'b0;
    else if (slot && hit) mis_q <= 1'b1;
  end
endmodule

// File: rtl/pcd_flag.sv
module pcd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mis_q,
  input  logic clr,
  output logic flag_q
);
  // A standing mismatch re-asserts the flag over any clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (mis_q) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] enable_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             q1_i,
  input  logic             flag_clr_i,
  output logic             flag_o
);
  import pcd_pkg::*;

  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] ref_q;
  logic             mis_q;

  pcd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_i),
    .dout (pin_s)
  );

  pcd_ref_latch #(.WIDTH(WIDTH)) u_ref (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rd_i),
    .pin_s(pin_s),
    .ref_q(ref_q),
    .rd_q (rd_data_o)
  );

  pcd_compare #(.WIDTH(WIDTH)) u_cmp (
    .clk  (clk),
    .rst_n(rst_n),
    .slot (q1_i),
    .rd   (rd_i),
    .pin_s(pin_s),
    .ref_q(ref_q),
    .en   (enable_i),
    .mis_q(mis_q)
  );

  pcd_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .mis_q (mis_q),
    .clr   (flag_clr_i),
    .flag_q(flag_o)
  );
endmodule

// File: rtl/pin_change_detect_checker.sv
module pin_change_detect_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] enable_i,
  input logic             rd_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             q1_i,
  input logic             flag_clr_i,
  input logic             flag_o,
  input logic [WIDTH-1:0] pin_s,
  input logic [WIDTH-1:0] ref_q,
  input logic             mis_q
);
  p_no_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!q1_i && !mis_q) |=> !mis_q);

  p_flag_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mis_q |=> flag_o);

  p_masked_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mis_q && ((pin_s ^ ref_q) & enable_i) == '0) |=> !mis_q);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_q && !rd_i) |=> mis_q);

  p_clr_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_q && flag_clr_i) |=> flag_o);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !mis_q);

  p_read_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (rd_data_o == $past(pin_s)) && (ref_q == $past(pin_s)));

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rd_data_o));
endmodule

bind pin_change_detect pin_change_detect_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable_i  (enable_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .q1_i      (q1_i),
  .flag_clr_i(flag_clr_i),
  .flag_o    (flag_o),
  .pin_s     (pin_s),
  .ref_q     (ref_q),
  .mis_q     (mis_q)
);

// File: tb/pin_change_detect_test.sv
`timescale 1ns/1ps
module pin_change_detect_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_i = '0;
  logic [W-1:0] enable_i = '0;
  logic         rd_i = 1'b0;
  logic         q1_i = 1'b0;
  logic         flag_clr_i = 1'b0;
  logic [W-1:0] rd_data_o;
  logic         flag_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Expected-state model built from the requirements
  logic [W-1:0] m_s1 = '0, m_s2 = '0, m_ref = '0, m_rd = '0;
  logic         m_mis = 1'b0, m_flag = 1'b0;

  always #4 clk = ~clk;

  pin_change_detect #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .enable_i  (enable_i),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .q1_i      (q1_i),
    .flag_clr_i(flag_clr_i),
    .flag_o    (flag_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: advance the model, then compare at the falling edge
  task automatic step();
    logic         nmis, nflag;
    @(posedge clk);
    if (rst_n) begin
      nflag = m_mis ? 1'b1 : (flag_clr_i ? 1'b0 : m_flag);
      if (rd_i) nmis = 1'b0;
      else if (q1_i && (((m_s2 ^ m_ref) & enable_i) != '0)) nmis = 1'b1;
      else nmis = m_mis;
      if (rd_i) begin
        m_ref = m_s2;
        m_rd  = m_s2;
      end
      m_s2   = m_s1;
      m_s1   = pin_i;
      m_mis  = nmis;
      m_flag = nflag;
    end
    @(negedge clk);
    check(flag_o == m_flag, "R4/R6 model flag", int'(flag_o), int'(m_flag));
    check(rd_data_o == m_rd, "R10 model read data", int'(rd_data_o), int'(m_rd));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_read();
    rd_i = 1'b1; step(); rd_i = 1'b0;
  endtask

  task automatic do_clr();
    flag_clr_i = 1'b1; step(); flag_clr_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(flag_o == 1'b0, "R1 flag at reset", int'(flag_o), 0);
    check(rd_data_o == '0, "R1 read data at reset", int'(rd_data_o), 0);
    rst_n = 1'b1;
    enable_i = '1;
    steps(2);
    check(flag_o == 1'b0, "R1 flag after reset", int'(flag_o), 0);

    // R2: synchroniser latency, comparison slot every cycle
    pin_i = 4'hA; q1_i = 1'b1;
    steps(3);
    check(flag_o == 1'b0, "R2 flag before latency", int'(flag_o), 0);
    step();
    check(flag_o == 1'b1, "R2 flag after latency", int'(flag_o), 1);
    q1_i = 1'b0;

    // R7: clear blocked by standing mismatch
    do_clr();
    check(flag_o == 1'b1, "R7 clear blocked", int'(flag_o), 1);

    // R6: pins return, flag and mismatch persist
    pin_i = 4'h0; q1_i = 1'b1;
    steps(4);
    do_clr();
    check(flag_o == 1'b1, "R6 sticky after return", int'(flag_o), 1);
    q1_i = 1'b0;

    // R8: read then clear succeeds
    do_read();
    check(rd_data_o == 4'h0, "R8 read data", int'(rd_data_o), 0);
    do_clr();
    check(flag_o == 1'b0, "R8 clear after read", int'(flag_o), 0);

    // R3: differences without a slot never flag
    pin_i = 4'h3;
    steps(6);
    check(flag_o == 1'b0, "R3 no slot no flag", int'(flag_o), 0);
    q1_i = 1'b1; step(); q1_i = 1'b0; step();
    check(flag_o == 1'b1, "R3 single slot flags", int'(flag_o), 1);
    do_read(); do_clr();
    check(flag_o == 1'b0, "R8 cleared", int'(flag_o), 0);
    check(rd_data_o == 4'h3, "R10 read value", int'(rd_data_o), 3);

    // R9: read and slot together, pin edge in flight
    pin_i = 4'h5; step();
    rd_i = 1'b1; q1_i = 1'b1; step(); rd_i = 1'b0;
    check(rd_data_o == 4'h3, "R9 read took old sync value", int'(rd_data_o), 3);
    check(flag_o == 1'b0, "R9 read wins", int'(flag_o), 0);
    step();
    check(flag_o == 1'b0, "R9 flag one edge later", int'(flag_o), 0);
    step();
    check(flag_o == 1'b1, "R9 edge caught next slot", int'(flag_o), 1);
    q1_i = 1'b0;
    do_read(); do_clr();

    // R5: masked pin ignored, its reference bit still reloads
    enable_i = 4'b1110; q1_i = 1'b1;
    pin_i = 4'h4;
    steps(6);
    check(flag_o == 1'b0, "R5 masked pin ignored", int'(flag_o), 0);
    q1_i = 1'b0;
    do_read();
    enable_i = 4'hF; q1_i = 1'b1;
    steps(6);
    check(flag_o == 1'b0, "R5 masked ref reloaded", int'(flag_o), 0);
    q1_i = 1'b0;

    // R10: read data holds while pins move
    held = rd_data_o;
    pin_i = 4'hB;
    steps(5);
    check(rd_data_o == held, "R10 hold", int'(rd_data_o), int'(held));
    do_read(); do_clr();

    // Sweep: every enable mask, three slot spacings, mixed reads and clears
    lfsr = 16'hACE1;
    for (int sp = 1; sp <= 4; sp = sp * 2) begin
      for (int en = 0; en < 16; en++) begin
        enable_i = en[W-1:0];
        for (int c = 0; c < 40; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          if (lfsr[2:0] == 3'd0) pin_i = lfsr[7:4];
          q1_i       = ((c % sp) == 0);
          rd_i       = (lfsr[11:9] == 3'd5);
          flag_clr_i = lfsr[14];
          step();
        end
        rd_i = 1'b0; flag_clr_i = 1'b0; q1_i = 1'b0;
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule